// File: doc/BRIEF.md
# Start-Symbol Gated Receive Clock

This block sits behind a data slicer and a bit-timing recovery circuit. Its inputs are the sliced receive bit, already synchronous to the system clock, and a one-cycle strobe that marks the centre of each bit. While recovery is enabled, the block shifts each strobed bit into a history register. It compares that history against a fixed start symbol. Until the symbol appears, the receive clock output stays low.

Once the symbol matches, the block latches into an active state. Every later strobe then produces one receive clock pulse, high for half a bit period. The strobed bit is placed on the receive data output at the rising edge of that pulse and is held there, so a host can sample it on the falling edge. The active state has no bit count limit. It ends only when the host drops the recovery-enable level or pulses the clear input. The block then returns to hunting, with an empty symbol history.

Top module: `rx_start_gate`

## Requirements
- R1: After reset, rxdclk and rxdata are 0 and the block is hunting for the start symbol.
- R2: While rec_en is 0, rxdclk stays 0 whatever arrives on slice_in and bit_stb, and a start symbol sent during that time is not remembered once rec_en returns to 1.
- R3: With rec_en at 1 and no start symbol yet matched, strobed bits produce no rxdclk pulse.
- R4: The start symbol is SYM_W (default 12) strobed bits equal to SYM (default 12'hACB), received most significant bit first. The strobe on which the last symbol bit arrives arms the block, and only later strobes produce pulses.
- R5: In the active state, a strobe at a rising system clock edge makes rxdclk go high after that edge, with rxdata equal to the slice_in value sampled with the strobe.
- R6: Each rxdclk pulse is high for exactly BIT_CYC/2 system clocks (4 by default), and rxdata does not change while rxdclk is high.
- R7: The active state continues for any number of bits, as long as rec_en stays 1 and host_clr stays 0.
- R8: A 1 on host_clr, or a 0 on rec_en, drives rxdclk and rxdata to 0 after the next clock edge and returns the block to hunting. A new start symbol is then needed.
- R9: The symbol history is emptied on every return to hunting. A start symbol split across a clear is therefore not detected, and a match needs SYM_W bits received since hunting began.
- R10: The symbol is found at any bit alignment, including when unrelated bits come before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_in | input | 1 | Sliced receive bit, synchronous to clk |
| bit_stb | input | 1 | One-cycle strobe, once per received bit |
| rec_en | input | 1 | Recovery enable level from host configuration |
| host_clr | input | 1 | One-cycle request to end the active state |
| rxdata | output | 1 | Recovered data bit, registered |
| rxdclk | output | 1 | Gated receive clock, registered |

## Verification
The pulse-width and data-stability properties rely on bit strobes arriving at least BIT_CYC/2 + 1 system clocks apart. A strobe that lands while a pulse is still high would restart it. The stimulus therefore always sends one strobe per BIT_CYC cycles and holds slice_in steady around each strobe. Clears and disables are applied only once a pulse has finished, so a fall is never cut short during a width check.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_ACTIVE = 1'b1
  } rsg_state_e;
endpackage

// File: rtl/rsg_sym_hunt.sv
module rsg_sym_hunt #(
  parameter int SYM_W = 12,
  parameter logic [SYM_W-1:0] SYM = 12'hACB
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stb,
  input  logic din,
  output logic hit
);
  localparam int CNT_W = $clog2(SYM_W + 1);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SYM_W);
  localparam logic [CNT_W-1:0] FILL_MIN = CNT_W'(SYM_W - 1);

  logic [SYM_W-1:0] hist_q;
  logic [CNT_W-1:0] fill_q;
  logic [SYM_W-1:0] hist_nxt;

  assign hist_nxt = {hist_q[SYM_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (stb) begin
      hist_q <= hist_nxt;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign hit = arm && stb && (fill_q >= FILL_MIN) && (hist_nxt == SYM);

  // R9: a disarmed hunter starts over with an empty history
  p_fresh_hist_r9: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (fill_q == '0));
endmodule

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clr,
  input  logic       hit,
  output rsg_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
    end else if (!en || clr) begin
      state <= ST_HUNT;
    end else if (hit) begin
      state <= ST_ACTIVE;
    end
  end

  p_enter_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_ACTIVE) |-> $past(hit));

  p_hold_active_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACTIVE && en && !clr) |=> (state == ST_ACTIVE));

  p_back_to_hunt_r8: assert property (@(posedge clk) disable iff (rst)
    (!en || clr) |=> (state == ST_HUNT));
endmodule

// File: rtl/rsg_pulse.sv
module rsg_pulse #(
  parameter int HI_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic en,
  input  logic clr,
  input  logic stb,
  input  logic din,
  output logic rxdclk,
  output logic rxdata
);
  localparam int CNT_W = (HI_CYC < 2) ? 1 : $clog2(HI_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HI_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || clr || !active) begin
      rxdclk <= 1'b0;
      rxdata <= 1'b0;
      cnt_q  <= '0;
    end else if (stb) begin
      rxdclk <= 1'b1;
      rxdata <= din;
      cnt_q  <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      rxdclk <= 1'b0;
    end
  end

  // checker-side width counter
  logic [CNT_W+1:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst || !rxdclk) hi_len <= '0;
    else                hi_len <= hi_len + 1'b1;
  end

  p_width_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(rxdclk) && $past(en) && !$past(clr)) |-> ($past(hi_len) + 1'b1 == (CNT_W+2)'(HI_CYC)));

  p_data_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (rxdclk && !$rose(rxdclk)) |-> $stable(rxdata));

  p_rise_data_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rxdclk) |-> ($past(stb) && rxdata == $past(din)));

  p_quiet_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rxdclk);

  p_quiet_hunt_r3: assert property (@(posedge clk) disable iff (rst)
    !active |-> !rxdclk);

  p_clear_low_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rxdclk && !rxdata));
endmodule

// File: rtl/rx_start_gate.sv
module rx_start_gate
  import rsg_pkg::*;
#(
  parameter int SYM_W = 12,
  parameter logic [SYM_W-1:0] SYM = 12'hACB,
  parameter int BIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic slice_in,
  input  logic bit_stb,
  input  logic rec_en,
  input  logic host_clr,
  output logic rxdata,
  output logic rxdclk
);
  localparam int HI_CYC = (BIT_CYC < 2) ? 1 : BIT_CYC / 2;

  rsg_state_e state;
  logic       arm;
  logic       hit;

  assign arm = (state == ST_HUNT) && rec_en && !host_clr;

  rsg_sym_hunt #(
    .SYM_W(SYM_W),
    .SYM  (SYM)
  ) u_hunt (
    .clk(clk),
    .rst(rst),
    .arm(arm),
    .stb(bit_stb),
    .din(slice_in),
    .hit(hit)
  );

  rsg_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .en   (rec_en),
    .clr  (host_clr),
    .hit  (hit),
    .state(state)
  );

  rsg_pulse #(
    .HI_CYC(HI_CYC)
  ) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .active(state == ST_ACTIVE),
    .en    (rec_en),
    .clr   (host_clr),
    .stb   (bit_stb),
    .din   (slice_in),
    .rxdclk(rxdclk),
    .rxdata(rxdata)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rxdclk && !rxdata && state == ST_HUNT));
endmodule

// File: tb/rx_start_gate_bench.sv
module rx_start_gate_bench;
  localparam int SYM_W = 12;
  localparam logic [SYM_W-1:0] SYM = 12'hACB;
  localparam int BIT_CYC = 8;
  localparam int HI_EXP = BIT_CYC / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slice_in = 1'b0;
  logic bit_stb = 1'b0;
  logic rec_en = 1'b0;
  logic host_clr = 1'b0;
  logic rxdata;
  logic rxdclk;

  int n_tests = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  bit finished = 1'b0;
  logic exp_q[$];

  always #4 clk = ~clk;

  rx_start_gate #(.SYM_W(SYM_W), .SYM(SYM), .BIT_CYC(BIT_CYC)) u_rx_start_gate (
    .clk(clk), .rst(rst), .slice_in(slice_in), .bit_stb(bit_stb),
    .rec_en(rec_en), .host_clr(host_clr), .rxdata(rxdata), .rxdclk(rxdclk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one strobe per BIT_CYC cycles; pushes expected bits when a pulse is due
  task automatic send_bit(input logic b, input bit expect_pulse);
    @(negedge clk);
    slice_in = b;
    bit_stb = 1'b1;
    if (expect_pulse) exp_q.push_back(b);
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (BIT_CYC - 2) @(negedge clk);
  endtask

  task automatic send_sym();
    for (int i = SYM_W - 1; i >= 0; i--) send_bit(SYM[i], 1'b0);
  endtask

  // monitor / scoreboard
  logic prev_clk = 1'b0;
  int hi_cnt = 0;
  logic held = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rxdclk && !prev_clk) begin
        rise_cnt++;
        hi_cnt = 1;
        held = rxdata;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected rxdclk pulse", 1, 0);
        end else begin
          logic e;
          e = exp_q.pop_front();
          chk(rxdata == e, "R5 rxdata at pulse", int'(rxdata), int'(e));
        end
      end else if (rxdclk) begin
        hi_cnt++;
        chk(rxdata == held, "R6 rxdata stable while high", int'(rxdata), int'(held));
      end else if (prev_clk) begin
        chk(hi_cnt == HI_EXP, "R6 pulse width", hi_cnt, HI_EXP);
      end
    end
    prev_clk = rxdclk;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rxdclk == 1'b0, "R1 rxdclk after reset", int'(rxdclk), 0);
    chk(rxdata == 1'b0, "R1 rxdata after reset", int'(rxdata), 0);

    // R2: disabled, symbol and data ignored
    base = rise_cnt;
    send_sym();
    for (int i = 0; i < 6; i++) send_bit(i[0], 1'b0);
    chk(rxdclk == 1'b0, "R2 rxdclk low while disabled", int'(rxdclk), 0);
    chk(rise_cnt == base, "R2 no pulse while disabled", rise_cnt - base, 0);

    // R2/R3: enable, no symbol yet
    rec_en = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(i[1], 1'b0);
    chk(rise_cnt == base, "R3 no pulse before symbol", rise_cnt - base, 0);

    // R4/R5/R6/R7: symbol then a long run of bits
    send_sym();
    chk(rise_cnt == base, "R4 symbol bits give no pulse", rise_cnt - base, 0);
    for (int i = 0; i < 40; i++) send_bit(((i * 7) % 5) > 1, 1'b1);
    chk(rise_cnt - base == 40, "R7 pulses for every bit", rise_cnt - base, 40);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    // R8: host clear
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    chk(rxdclk == 1'b0, "R8 rxdclk low after clear", int'(rxdclk), 0);
    chk(rxdata == 1'b0, "R8 rxdata low after clear", int'(rxdata), 0);
    base = rise_cnt;
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
    chk(rise_cnt == base, "R8 hunting after clear", rise_cnt - base, 0);

    // R9: symbol split across a clear
    for (int i = SYM_W - 1; i >= SYM_W / 2; i--) send_bit(SYM[i], 1'b0);
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    for (int i = SYM_W / 2 - 1; i >= 0; i--) send_bit(SYM[i], 1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    chk(rise_cnt == base, "R9 split symbol not detected", rise_cnt - base, 0);

    // R10: unaligned symbol after junk, then disable via rec_en
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_sym();
    for (int i = 0; i < 6; i++) send_bit(i[0] ^ i[2], 1'b1);
    chk(rise_cnt - base == 6, "R10 symbol found after junk", rise_cnt - base, 6);
    @(negedge clk);
    rec_en = 1'b0;
    @(negedge clk);
    chk(rxdclk == 1'b0, "R8 rxdclk low after disable", int'(rxdclk), 0);
    chk(rxdata == 1'b0, "R8 rxdata low after disable", int'(rxdata), 0);
    rec_en = 1'b1;
    base = rise_cnt;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    chk(rise_cnt == base, "R8 new symbol needed after disable", rise_cnt - base, 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty at end", exp_q.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule